// File: doc/BRIEF.md
# Paired-Word Memory Loader

This block prepares a data memory before a program starts. After a start pulse it announces which application it wants by writing a small index to an output I/O channel. It then pulls 34-bit words from an input I/O channel one at a time. The words come in twos: an address word, then a data word. Each ordinary pair becomes one write on a synchronous memory port.

An address word whose 34 bits are all ones ends the stream. The data word that follows such an address is never written to memory. It is kept as the program's first instruction address. The loader then raises a done flag next to that value and stays parked until reset, so the code that runs the program can take over.

Both I/O directions use a request/acknowledge handshake. A request stays up until its acknowledge arrives, and the loader moves on only in the cycle of that acknowledge.

Top module: `pair_loader`

## Requirements
- R1: While reset is applied, and until a start pulse is seen, io_rd_req, io_wr_req, mem_we and done are all 0 and entry_pc is 0.
- R2: A start pulse seen while idle raises io_wr_req on channel 1 (io_wr_chan = 1). io_wr_data carries app_sel zero-extended to 34 bits. The request is held until io_wr_ack, and no read request is made before that acknowledge.
- R3: Every word is fetched by raising io_rd_req on channel 1 (io_rd_chan = 1) and holding it until io_rd_ack. The word on io_rd_data is taken in the acknowledge cycle.
- R4: For a pair whose address word is not all ones, mem_we is 1 for exactly one cycle, the cycle after the data word's acknowledge. In that cycle mem_addr carries the address word and mem_wdata carries the data word.
- R5: Only address bits 11:0 reach mem_addr; bits 33:12 of the address word are ignored. An address word that differs from all ones in any bit, such as 0x3FFFFFFFE, is an ordinary address.
- R6: When the address word is 0x3FFFFFFFF, its data word is not written. In the cycle after that word's acknowledge, done rises and entry_pc equals the data word.
- R7: Once done is 1, it stays 1 and entry_pc stays fixed until reset. No further I/O request or memory write occurs, further start pulses are ignored, and unread words are left in the source.
- R8: io_rd_req and io_wr_req are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begins a load when the loader is idle |
| app_sel | input | 2 | Index of the application to request |
| io_rd_req | output | 1 | Read request on the I/O port |
| io_rd_chan | output | 4 | Input channel number for the read |
| io_rd_ack | input | 1 | Read acknowledge; data valid in this cycle |
| io_rd_data | input | 34 | Word returned by the read |
| io_wr_req | output | 1 | Write request on the I/O port |
| io_wr_chan | output | 4 | Output channel number for the write |
| io_wr_data | output | 34 | Word sent by the write |
| io_wr_ack | input | 1 | Write acknowledge |
| mem_we | output | 1 | Memory write enable, one cycle per stored pair |
| mem_addr | output | 12 | Memory word address |
| mem_wdata | output | 34 | Memory write data |
| done | output | 1 | Loading finished (sticky) |
| entry_pc | output | 34 | Entry address taken from the end marker's data word |

## Verification
The loader is tried with four kinds of stream, and a per-cycle reference model follows each one.
- A mixed stream with zero-latency acknowledges includes an address with high bits set and the near-marker value 0x3FFFFFFFE. It separates truncation to 12 bits from end-marker detection.
- A stream that holds only the end marker, with slow acknowledges, shows that request holding works and that no write happens for a marker pair.
- A stream that writes the same address twice, with acknowledge gaps that vary, checks write order and the one-cycle write enable.
- Words left in the source after the marker, plus extra start pulses, show that the done state really stops all traffic.

// File: rtl/loader_pkg.sv
package loader_pkg;

  typedef enum logic [2:0] {
    LD_IDLE    = 3'd0,
    LD_SELECT  = 3'd1,
    LD_RD_ADDR = 3'd2,
    LD_RD_DATA = 3'd3,
    LD_WRITE   = 3'd4,
    LD_DONE    = 3'd5
  } ld_state_e;

endpackage

// File: rtl/loader_rst_sync.sv
module loader_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q <= '0;
        else         chain_q <= 1'b1;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/loader_fsm.sv
module loader_fsm
  import loader_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  logic      wr_ack,
  input  logic      rd_ack,
  input  logic      addr_is_end,
  output ld_state_e state
);

  ld_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      LD_IDLE:    if (start)  state_d = LD_SELECT;
      LD_SELECT:  if (wr_ack) state_d = LD_RD_ADDR;
      LD_RD_ADDR: if (rd_ack) state_d = LD_RD_DATA;
      LD_RD_DATA: if (rd_ack) state_d = addr_is_end ? LD_DONE : LD_WRITE;
      LD_WRITE:               state_d = LD_RD_ADDR;
      LD_DONE:                state_d = LD_DONE;
      default:                state_d = LD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= LD_IDLE;
    else        state_q <= state_d;
  end

  assign state = state_q;

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == LD_DONE |=> state_q == LD_DONE); // R7

  AST_WRITE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == LD_WRITE |=> state_q == LD_RD_ADDR); // R4

  AST_SELECT_BEFORE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LD_SELECT && !wr_ack) |=> state_q == LD_SELECT); // R2

endmodule

// File: rtl/loader_datapath.sv
module loader_datapath
  import loader_pkg::*;
#(
  parameter int DATA_W = 34,
  parameter int APP_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ld_state_e         state,
  input  logic              start,
  input  logic              rd_ack,
  input  logic [DATA_W-1:0] rd_data,
  input  logic [APP_W-1:0]  app_sel,
  output logic [APP_W-1:0]  app_q,
  output logic [DATA_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q,
  output logic [DATA_W-1:0] entry_q,
  output logic              addr_is_end
);

  logic app_en, addr_en, data_en, entry_en;

  assign addr_is_end = &addr_q;

  always_comb begin
    app_en   = (state == LD_IDLE) && start;
    addr_en  = (state == LD_RD_ADDR) && rd_ack;
    data_en  = (state == LD_RD_DATA) && rd_ack && !addr_is_end;
    entry_en = (state == LD_RD_DATA) && rd_ack && addr_is_end;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      app_q <= '0;
    else if (app_en) app_q <= app_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= rd_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= rd_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        entry_q <= '0;
    else if (entry_en) entry_q <= rd_data;
  end

  AST_MARKER_NOT_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    state == LD_WRITE |-> !addr_is_end); // R6

  AST_ADDR_HELD_FOR_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    state == LD_RD_DATA |=> $stable(addr_q)); // R3

endmodule

// File: rtl/pair_loader.sv
module pair_loader
  import loader_pkg::*;
#(
  parameter int DATA_W      = 34,
  parameter int IO_AW       = 4,
  parameter int MEM_AW      = 12,
  parameter int APP_W       = 2,
  parameter int SEL_CHAN    = 1,
  parameter int SRC_CHAN    = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [APP_W-1:0]  app_sel,
  output logic              io_rd_req,
  output logic [IO_AW-1:0]  io_rd_chan,
  input  logic              io_rd_ack,
  input  logic [DATA_W-1:0] io_rd_data,
  output logic              io_wr_req,
  output logic [IO_AW-1:0]  io_wr_chan,
  output logic [DATA_W-1:0] io_wr_data,
  input  logic              io_wr_ack,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              done,
  output logic [DATA_W-1:0] entry_pc
);

  localparam logic [IO_AW-1:0] SEL_CHAN_V = IO_AW'(SEL_CHAN);
  localparam logic [IO_AW-1:0] SRC_CHAN_V = IO_AW'(SRC_CHAN);
  localparam int               PAD_W      = DATA_W - APP_W;

  logic              rst_sync_n;
  ld_state_e         state;
  logic [APP_W-1:0]  app_q;
  logic [DATA_W-1:0] addr_q, data_q, entry_q;
  logic              addr_is_end;

  loader_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_sync_n)
  );

  loader_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .start       (start),
    .wr_ack      (io_wr_ack),
    .rd_ack      (io_rd_ack),
    .addr_is_end (addr_is_end),
    .state       (state)
  );

  loader_datapath #(.DATA_W(DATA_W), .APP_W(APP_W)) u_dp (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .state       (state),
    .start       (start),
    .rd_ack      (io_rd_ack),
    .rd_data     (io_rd_data),
    .app_sel     (app_sel),
    .app_q       (app_q),
    .addr_q      (addr_q),
    .data_q      (data_q),
    .entry_q     (entry_q),
    .addr_is_end (addr_is_end)
  );

  always_comb begin
    io_rd_req  = (state == LD_RD_ADDR) || (state == LD_RD_DATA);
    io_wr_req  = (state == LD_SELECT);
    mem_we     = (state == LD_WRITE);
    done       = (state == LD_DONE);
    io_rd_chan = SRC_CHAN_V;
    io_wr_chan = SEL_CHAN_V;
    io_wr_data = {{PAD_W{1'b0}}, app_q};
    mem_addr   = addr_q[MEM_AW-1:0];
    mem_wdata  = data_q;
    entry_pc   = entry_q;
  end

  AST_NO_DUAL_REQ: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(io_rd_req && io_wr_req)); // R8

  AST_RD_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (io_rd_req && !io_rd_ack) |=> io_rd_req); // R3

  AST_WR_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (io_wr_req && !io_wr_ack) |=> io_wr_req); // R2

  AST_WE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_we |-> $past(io_rd_ack)); // R4

  AST_ENTRY_FROZEN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |=> (done && $stable(entry_pc) && !mem_we && !io_rd_req)); // R7

endmodule

// File: tb/pair_loader_tb_top.sv
module pair_loader_tb_top;

  localparam logic [33:0] END_MARK = 34'h3FFFFFFFF;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [1:0]  app_sel;
  logic        io_rd_req, io_wr_req, io_rd_ack, io_wr_ack;
  logic [3:0]  io_rd_chan, io_wr_chan;
  logic [33:0] io_rd_data, io_wr_data, mem_wdata, entry_pc;
  logic        mem_we, done;
  logic [11:0] mem_addr;

  always #4 clk = ~clk;

  pair_loader dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .app_sel(app_sel),
    .io_rd_req(io_rd_req), .io_rd_chan(io_rd_chan), .io_rd_ack(io_rd_ack),
    .io_rd_data(io_rd_data), .io_wr_req(io_wr_req), .io_wr_chan(io_wr_chan),
    .io_wr_data(io_wr_data), .io_wr_ack(io_wr_ack), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .done(done), .entry_pc(entry_pc)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit compare_on = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // Source stream, device latency and expected memory
  logic [33:0] stream[$];
  logic [33:0] exp_mem[int];
  logic [33:0] got_mem[int];
  int exp_writes, got_writes, gap_base, gap_var, rd_wait, wr_wait, n_acks;
  logic [33:0] exp_entry;

  task automatic push_pair(input logic [33:0] a, input logic [33:0] d);
    stream.push_back(a);
    stream.push_back(d);
    if (a != END_MARK) begin
      exp_mem[int'(a[11:0])] = d;
      exp_writes++;
    end else begin
      exp_entry = d;
    end
  endtask

  // Behavioural reference model: expected phase of the transfer
  int          m_ph;
  logic [33:0] m_addr, m_data, m_entry;
  logic [1:0]  m_app;

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      chk(1'b0, "watchdog", 64'(cyc), 64'd0);
      summary();
    end
    if (!rst_n) begin
      m_ph = 0; m_addr = '0; m_data = '0; m_entry = '0; m_app = '0;
    end else begin
      if (mem_we) begin
        got_mem[int'(mem_addr)] = mem_wdata;
        got_writes++;
      end
      case (m_ph)
        0: if (start) begin m_app = app_sel; m_ph = 1; end
        1: if (io_wr_ack) m_ph = 2;
        2: if (io_rd_ack) begin m_addr = io_rd_data; m_ph = 3; end
        3: if (io_rd_ack) begin
             if (m_addr == END_MARK) begin m_entry = io_rd_data; m_ph = 5; end
             else begin m_data = io_rd_data; m_ph = 4; end
           end
        4: m_ph = 2;
        default: m_ph = m_ph;
      endcase
    end
  end

  // Negedge: compare outputs with the model, then act as the I/O device
  always @(negedge clk) begin
    if (compare_on) begin
      chk(io_rd_req == (m_ph == 2 || m_ph == 3), "R3 rd_req", 64'(io_rd_req), 64'(m_ph == 2 || m_ph == 3));
      chk(io_wr_req == (m_ph == 1), "R2 wr_req", 64'(io_wr_req), 64'(m_ph == 1));
      chk(mem_we == (m_ph == 4), "R4 mem_we", 64'(mem_we), 64'(m_ph == 4));
      chk(done == (m_ph == 5), "R6 done", 64'(done), 64'(m_ph == 5));
      chk(!(io_rd_req && io_wr_req), "R8 dual request", 64'(io_rd_req), 64'd0);
      if (m_ph == 5) chk(entry_pc == m_entry, "R6 entry_pc", 64'(entry_pc), 64'(m_entry));
      if (m_ph == 1) begin
        chk(io_wr_chan == 4'd1, "R2 wr_chan", 64'(io_wr_chan), 64'd1);
        chk(io_wr_data == 34'(m_app), "R2 wr_data", 64'(io_wr_data), 64'(m_app));
      end
      if (m_ph == 2 || m_ph == 3) chk(io_rd_chan == 4'd1, "R3 rd_chan", 64'(io_rd_chan), 64'd1);
      if (m_ph == 4) begin
        chk(mem_addr == m_addr[11:0], "R5 mem_addr", 64'(mem_addr), 64'(m_addr[11:0]));
        chk(mem_wdata == m_data, "R4 mem_wdata", 64'(mem_wdata), 64'(m_data));
      end
    end
    if (io_rd_ack) void'(stream.pop_front());
    io_rd_ack = 1'b0;
    io_wr_ack = 1'b0;
    if (io_rd_req && stream.size() > 0) begin
      if (rd_wait >= gap_base + (n_acks % 2) * gap_var) begin
        io_rd_ack = 1'b1; io_rd_data = stream[0]; rd_wait = 0; n_acks++;
      end else rd_wait++;
    end
    if (io_wr_req) begin
      if (wr_wait >= gap_base) begin io_wr_ack = 1'b1; wr_wait = 0; end
      else wr_wait++;
    end
  end

  task automatic do_reset();
    compare_on = 0;
    @(negedge clk);
    rst_n = 1'b0; start = 1'b0;
    stream.delete(); exp_mem.delete(); got_mem.delete();
    exp_writes = 0; got_writes = 0; exp_entry = '0;
    rd_wait = 0; wr_wait = 0; n_acks = 0;
    repeat (3) @(negedge clk);
    chk(!io_rd_req && !io_wr_req && !mem_we && !done, "R1 outputs in reset",
        64'({io_rd_req, io_wr_req, mem_we, done}), 64'd0);
    chk(entry_pc == 34'd0, "R1 entry in reset", 64'(entry_pc), 64'd0);
    rst_n = 1'b1;
    compare_on = 1;
    repeat (5) @(negedge clk);
    chk(!io_rd_req && !io_wr_req && !done, "R1 idle before start",
        64'({io_rd_req, io_wr_req, done}), 64'd0);
  endtask

  task automatic run_load(input logic [1:0] app, input int trailing);
    int guard = 0;
    app_sel = app;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && guard < 5000) begin @(negedge clk); guard++; end
    chk(done, "R6 done reached", 64'(done), 64'd1);
    chk(entry_pc == exp_entry, "R6 entry value", 64'(entry_pc), 64'(exp_entry));
    chk(got_writes == exp_writes, "R4 write count", 64'(got_writes), 64'(exp_writes));
    foreach (exp_mem[k]) begin
      chk(got_mem.exists(k) && got_mem[k] == exp_mem[k], "R5 memory word",
          got_mem.exists(k) ? 64'(got_mem[k]) : 64'hDEAD, 64'(exp_mem[k]));
    end
    // R7: further starts are ignored and trailing words stay unread
    start = 1'b1;
    repeat (3) @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    chk(done && entry_pc == exp_entry, "R7 done sticky", 64'(entry_pc), 64'(exp_entry));
    chk(stream.size() == trailing, "R7 words left unread", 64'(stream.size()), 64'(trailing));
    chk(got_writes == exp_writes, "R7 no write after done", 64'(got_writes), 64'(exp_writes));
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; app_sel = 2'd0;
    io_rd_ack = 1'b0; io_wr_ack = 1'b0; io_rd_data = '0;
    gap_base = 0; gap_var = 0;

    // Mixed stream, zero-latency device; R5 truncation and near-marker address
    do_reset();
    gap_base = 0; gap_var = 0;
    push_pair(34'd3, 34'd0);
    push_pair(34'd5, 34'h12345);
    push_pair(34'h1_0000_0007, 34'h3FFFFFFFF);
    push_pair(34'h3FFFFFFFE, 34'hAA);
    push_pair(34'h0_0000_0FFF, 34'h2_5555_5555);
    push_pair(END_MARK, 34'h40);
    stream.push_back(34'h7);
    stream.push_back(34'h8);
    run_load(2'd0, 2);

    // Marker only, slow device: R6 no write, R2/R3 request holding
    do_reset();
    gap_base = 3; gap_var = 0;
    push_pair(END_MARK, 34'h99);
    run_load(2'd2, 0);

    // Same address twice, alternating gaps: last write wins
    do_reset();
    gap_base = 1; gap_var = 2;
    push_pair(34'h10, 34'h1);
    push_pair(34'h10, 34'h2);
    push_pair(34'h2_0000_0010, 34'h3);
    push_pair(34'h20, 34'h1_ABCD_0123);
    push_pair(END_MARK, 34'h3_0000_0001);
    stream.push_back(END_MARK);
    run_load(2'd3, 1);

    compare_on = 0;
    summary();
  end

endmodule